// File: doc/BRIEF.md
# Fetch-Stage Next-PC Predictor

This block picks the address a five-stage pipeline fetches from next. The fetch stage decodes the current instruction into a control class and supplies its immediate target and its fall-through address. From these, the block forms a static prediction of the following PC and stores it in a predicted-PC register. Conditional branches follow one of three static policies, chosen by a configuration input. A return cannot be predicted at fetch. The block raises a flag for it so the surrounding control can hold fetch until the return address is known.

On every cycle, the fetch address comes from one of three sources. A branch that resolves as mispredicted in the memory stage redirects fetch to the path that was not taken. A return that reaches write-back supplies its popped address. In all other cycles, fetch uses the stored prediction.

Top module: `fetch_pc_predict`

## Requirements
- R1: For class 1 (unconditional jump) and class 2 (call), `pred_pc` equals `imm_target` and `pred_taken` is 0.
- R2: For classes 0, 5, 6 and 7 (plain instructions), `pred_pc` equals `fall_addr`, `pred_taken` is 0 and `ret_unpred` is 0.
- R3: For class 3 (conditional branch) with `policy` 2'b00 (always taken), `pred_pc` equals `imm_target` and `pred_taken` is 1.
- R4: For class 3 with `policy` 2'b01 (never taken) or the unused code 2'b11, `pred_pc` equals `fall_addr` and `pred_taken` is 0.
- R5: For class 3 with `policy` 2'b10, the branch is predicted taken (`pred_pc` = `imm_target`, `pred_taken` = 1) only when `imm_target` is below `instr_pc` in an unsigned compare. When the two are equal or the target is higher, it predicts `fall_addr` with `pred_taken` 0.
- R6: For class 4 (return), `ret_unpred` is 1 and `pred_pc` equals `fall_addr`. `ret_unpred` is 0 for every other class.
- R7: After reset, `fetch_pc` equals parameter RESET_PC. With no override active, `fetch_pc` equals the `pred_pc` value presented at the previous rising clock edge outside reset.
- R8: When `mem_mispredict` is 1, `fetch_pc` is `mem_fall` if `mem_was_taken` is 1 and `mem_target` otherwise. This holds regardless of `wb_ret_valid`.
- R9: When `wb_ret_valid` is 1 and `mem_mispredict` is 0, `fetch_pc` equals `wb_ret_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy | input | 2 | Static conditional-branch policy |
| op_class | input | 3 | Control class of the fetched instruction |
| instr_pc | input | AW | Address of the fetched instruction |
| imm_target | input | AW | Immediate target of the fetched instruction |
| fall_addr | input | AW | Sequential address after the fetched instruction |
| mem_mispredict | input | 1 | Branch in memory stage resolved against its prediction |
| mem_was_taken | input | 1 | That branch had been predicted taken |
| mem_target | input | AW | That branch's immediate target |
| mem_fall | input | AW | That branch's fall-through address |
| wb_ret_valid | input | 1 | Return in write-back with its address ready |
| wb_ret_addr | input | AW | Return address from write-back |
| pred_pc | output | AW | Predicted next PC for the fetched instruction |
| pred_taken | output | 1 | Conditional branch predicted taken |
| ret_unpred | output | 1 | Fetched instruction is a return and cannot be predicted |
| fetch_pc | output | AW | Selected fetch address for this cycle |

## Verification
The mispredict correction and the write-back return address can both be active in the same cycle. In that case the correction must win. The random stream raises each of the two override inputs in about one cycle in six and independently of each other, so such overlaps occur many times. A directed cycle also forces both at once. In each case, the bench compares `fetch_pc` against a model of the priority and of the stored prediction from the previous cycle.

// File: rtl/fetch_pc_predict.sv
module fetch_pc_predict #(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    policy,
  input  logic [2:0]    op_class,
  input  logic [AW-1:0] instr_pc,
  input  logic [AW-1:0] imm_target,
  input  logic [AW-1:0] fall_addr,
  input  logic          mem_mispredict,
  input  logic          mem_was_taken,
  input  logic [AW-1:0] mem_target,
  input  logic [AW-1:0] mem_fall,
  input  logic          wb_ret_valid,
  input  logic [AW-1:0] wb_ret_addr,
  output logic [AW-1:0] pred_pc,
  output logic          pred_taken,
  output logic          ret_unpred,
  output logic [AW-1:0] fetch_pc
);

  localparam logic [2:0] C_JMP  = 3'd1;
  localparam logic [2:0] C_CALL = 3'd2;
  localparam logic [2:0] C_BR   = 3'd3;
  localparam logic [2:0] C_RET  = 3'd4;

  localparam logic [1:0] P_TAKEN = 2'b00;
  localparam logic [1:0] P_BTFN  = 2'b10;

  logic [AW-1:0] pc_q;
  logic          is_br, backward, br_take, uncond;

  assign is_br    = (op_class == C_BR);
  assign uncond   = (op_class == C_JMP) || (op_class == C_CALL);
  assign backward = (imm_target < instr_pc);

  always_comb begin
    case (policy)
      P_TAKEN: br_take = 1'b1;
      P_BTFN:  br_take = backward;
      default: br_take = 1'b0;
    endcase
  end

  assign pred_taken = is_br && br_take;
  assign ret_unpred = (op_class == C_RET);
  assign pred_pc    = (uncond || pred_taken) ? imm_target : fall_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pred_pc;
  end

  assign fetch_pc = mem_mispredict ? (mem_was_taken ? mem_fall : mem_target)
                  : wb_ret_valid   ? wb_ret_addr
                  : pc_q;

  a_r1_uncond_target: assert property (@(posedge clk) disable iff (!rst_n)
    uncond |-> (pred_pc == imm_target) && !pred_taken);

  a_r6_ret_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ret_unpred |-> (pred_pc == fall_addr) && !pred_taken);

  a_r5_btfn_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (is_br && policy == P_BTFN && imm_target >= instr_pc) |-> !pred_taken);

  a_r7_holds_pred: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mem_mispredict || wb_ret_valid || fetch_pc == $past(pred_pc)));

  a_r8_correct_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_mispredict && mem_was_taken) |-> (fetch_pc == mem_fall));

  a_r9_ret_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_ret_valid && !mem_mispredict) |-> (fetch_pc == wb_ret_addr));

endmodule

// File: tb/sim_fetch_pc_predict.sv
`timescale 1ns/1ps
module sim_fetch_pc_predict;
  localparam int AW = 32;
  localparam logic [AW-1:0] RPC = 32'h0000_0100;

  logic clk = 0, rst_n = 0;
  logic [1:0] policy = 0;
  logic [2:0] op_class = 0;
  logic [AW-1:0] instr_pc = 0, imm_target = 0, fall_addr = 0;
  logic mem_mispredict = 0, mem_was_taken = 0, wb_ret_valid = 0;
  logic [AW-1:0] mem_target = 0, mem_fall = 0, wb_ret_addr = 0;
  logic [AW-1:0] pred_pc, fetch_pc;
  logic pred_taken, ret_unpred;

  int tests = 0, fails = 0;
  logic [AW-1:0] model_pc;

  always #10 clk = ~clk;

  fetch_pc_predict #(.AW(AW), .RESET_PC(RPC)) u0 (
    .clk(clk), .rst_n(rst_n), .policy(policy), .op_class(op_class),
    .instr_pc(instr_pc), .imm_target(imm_target), .fall_addr(fall_addr),
    .mem_mispredict(mem_mispredict), .mem_was_taken(mem_was_taken),
    .mem_target(mem_target), .mem_fall(mem_fall),
    .wb_ret_valid(wb_ret_valid), .wb_ret_addr(wb_ret_addr),
    .pred_pc(pred_pc), .pred_taken(pred_taken), .ret_unpred(ret_unpred),
    .fetch_pc(fetch_pc));

  function automatic logic exp_taken(input logic [2:0] c, input logic [1:0] p,
                                     input logic [AW-1:0] t, input logic [AW-1:0] pc);
    if (c != 3'd3) return 1'b0;
    if (p == 2'b00) return 1'b1;
    if (p == 2'b10) return t < pc;
    return 1'b0;
  endfunction

  function automatic logic [AW-1:0] exp_pred(input logic [2:0] c, input logic [1:0] p,
                                             input logic [AW-1:0] t, input logic [AW-1:0] f,
                                             input logic [AW-1:0] pc);
    if (c == 3'd1 || c == 3'd2) return t;
    if (exp_taken(c, p, t, pc)) return t;
    return f;
  endfunction

  function automatic logic [AW-1:0] exp_fetch(input logic [AW-1:0] held);
    if (mem_mispredict) return mem_was_taken ? mem_fall : mem_target;
    if (wb_ret_valid) return wb_ret_addr;
    return held;
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] c, input logic [1:0] p);
    if (c == 3'd1 || c == 3'd2) return "R1";
    if (c == 3'd4) return "R6";
    if (c != 3'd3) return "R2";
    if (p == 2'b00) return "R3";
    if (p == 2'b10) return "R5";
    return "R4";
  endfunction

  task automatic check_all();
    string r;
    string fr;
    r = req_of(op_class, policy);
    fr = mem_mispredict ? "R8" : (wb_ret_valid ? "R9" : "R7");
    chk(r, pred_pc, exp_pred(op_class, policy, imm_target, fall_addr, instr_pc));
    chk(r, {31'b0, pred_taken}, {31'b0, exp_taken(op_class, policy, imm_target, instr_pc)});
    chk("R6", {31'b0, ret_unpred}, {31'b0, op_class == 3'd4});
    chk(fr, fetch_pc, exp_fetch(model_pc));
  endtask

  task automatic step();
    #2 check_all();
    @(negedge clk);
    model_pc = exp_pred(op_class, policy, imm_target, fall_addr, instr_pc);
  endtask

  initial begin
    #(20ns * 200000);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_pc = RPC;
    #2 chk("R7", fetch_pc, RPC);

    // R5 equal target: forward, not taken
    op_class = 3'd3; policy = 2'b10; instr_pc = 32'h40; imm_target = 32'h40; fall_addr = 32'h42;
    step();
    // R5 backward by one
    imm_target = 32'h3F;
    step();
    // R4 unused policy code
    policy = 2'b11; imm_target = 32'h10;
    step();
    // R8 and R9 together: correction wins
    op_class = 3'd0; mem_mispredict = 1; mem_was_taken = 0; mem_target = 32'hAAAA;
    mem_fall = 32'hBBBB; wb_ret_valid = 1; wb_ret_addr = 32'hCCCC;
    step();
    mem_was_taken = 1;
    step();
    mem_mispredict = 0;
    step();
    wb_ret_valid = 0; op_class = 3'd4;
    step();

    for (int i = 0; i < 400; i++) begin
      op_class = 3'($urandom % 8);
      if ($urandom % 3 == 0) op_class = 3'd3;
      policy = 2'($urandom % 4);
      instr_pc = $urandom; imm_target = $urandom; fall_addr = instr_pc + 32'd5;
      mem_mispredict = ($urandom % 6) == 0; mem_was_taken = 1'($urandom);
      mem_target = $urandom; mem_fall = $urandom;
      wb_ret_valid = ($urandom % 6) == 0; wb_ret_addr = $urandom;
      step();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule